// File: doc/BRIEF.md
# Page-Mode DRAM Cycle Decoder Model

A synthesizable, scaled-down model of an asynchronous page-mode DRAM. It samples the active-low row strobe, column strobe, write enable and output enable on a fast system clock. It sorts every access into one of nine cycle kinds and acts on each one. It holds a small data array, an internal refresh row pointer and a split 4-bit data port (input, output and output enable), which stands in for one bidirectional pin group.

It serves as the device-side target when a memory controller is verified. It reports the kind of the last decoded cycle and a map of rows whose refresh has lapsed, so checks on the controller side can read them. Array depth and address width are parameters. Address pins above the row and column widths are ignored.

Top module: `pgdram_model`

## Requirements
- R1: While `rst_ni` is low and right after reset, `dq_oe_o`, `self_ref_o` and `stale_err_o` are 0 and `cyc_type_o` is 0 (none).
- R2: If the write enable is low when the column strobe falls inside an open row, `dq_i` is written at that edge, `cyc_type_o` becomes 2 (early write), and `dq_oe_o` stays 0 even with the output enable low.
- R3: A column strobe fall with the write enable high loads the addressed word and sets `cyc_type_o` to 1 (read). `dq_oe_o` is 1 only while both the column strobe and the output enable are low, and 0 whenever the column strobe is high.
- R4: A write-enable fall during a read column cycle, with the output enable high and no data driven yet in that column cycle, writes `dq_i` and sets `cyc_type_o` to 3 (late write).
- R5: The same fall after the read data has been driven in that column cycle writes `dq_i` and sets `cyc_type_o` to 4 (read-modify-write).
- R6: A write-enable fall during a read column cycle while the output enable is low writes nothing. The output keeps driving the old word and `cyc_type_o` stays 1.
- R7: A row cycle with no column strobe fall reports `cyc_type_o` 5 at row strobe rise. It refreshes the row on the address pins and leaves the array unchanged.
- R8: A row strobe fall while the column strobe is already low is a counter refresh (`cyc_type_o` 6). It refreshes the row held in an internal pointer, which starts at 0 and advances by one, wrapping, for each such cycle. Address pins are ignored.
- R9: A counter refresh that starts while read data is being driven (column strobe held low across a row strobe high-low) reports `cyc_type_o` 7 (hidden) and keeps driving the same data.
- R10: After the row strobe has been low for SELF_CYC cycles in a counter refresh, `self_ref_o` rises and `cyc_type_o` becomes 8. While it is set, the pointer row is refreshed every REF_PERIOD/(2*rows) cycles. The next row strobe rise clears it.
- R11: `stale_map_o[r]` is 1 once row r has gone REF_PERIOD cycles without a refresh, and 0 again after its next refresh. `stale_err_o` is the OR of the map.
- R12: Only the low ROW_W address bits select the row and the low COL_W bits select the column. Higher address bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Multiplexed row/column address |
| dq_i | input | DW | Data from the bus |
| dq_o | output | DW | Data to the bus |
| dq_oe_o | output | 1 | Output drive enable |
| cyc_type_o | output | 4 | Last decoded cycle kind |
| self_ref_o | output | 1 | Self-refresh active |
| stale_map_o | output | 2**ROW_W | Rows whose refresh has lapsed |
| stale_err_o | output | 1 | Any row stale |

## Verification
The bench targets the edge-order corner cases. A write enable that falls one step before the column strobe must give an early write with a quiet bus. A decoder that mixed this up would drive read data or report a late write. Late writes are run both with and without data driven earlier and with the output enable low. A design that ignored the output enable on a late write would corrupt the stored word, and one that tracked no drive history would report the wrong kind. Refresh checks cover the pointer's start value, address-pin independence, hidden refresh keeping the driven word, the exact self-refresh entry and exit, and the staleness map both before and after refresh.

// File: rtl/pgdram_pkg.sv
package pgdram_pkg;
  typedef enum logic [3:0] {
    CYC_NONE     = 4'd0,
    CYC_READ     = 4'd1,
    CYC_EARLY_WR = 4'd2,
    CYC_LATE_WR  = 4'd3,
    CYC_RMW      = 4'd4,
    CYC_RAS_ONLY = 4'd5,
    CYC_CBR      = 4'd6,
    CYC_HIDDEN   = 4'd7,
    CYC_SELF     = 4'd8
  } cyc_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_OPEN,
    ST_CBR,
    ST_SELF
  } st_e;
endpackage

// File: rtl/pgdram_edge.sv
module pgdram_edge #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] fall_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= '1;
    else         sig_q <= sig_i;
  end

  assign fall_o = sig_q & ~sig_i;
  assign rise_o = ~sig_q & sig_i;
endmodule

// File: rtl/pgdram_array.sv
module pgdram_array #(
  parameter int AW = 5,
  parameter int DW = 4
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/pgdram_refresh.sv
module pgdram_refresh #(
  parameter int ROW_W      = 3,
  parameter int REF_PERIOD = 2000,
  parameter int SELF_CYC   = 400
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ext_en_i,
  input  logic [ROW_W-1:0]        ext_row_i,
  input  logic                    cbr_en_i,
  input  logic                    cbr_hold_i,
  input  logic                    self_act_i,
  output logic                    self_go_o,
  output logic [(1<<ROW_W)-1:0]   stale_map_o
);
  localparam int ROWS      = 1 << ROW_W;
  localparam int STEP_RAW  = REF_PERIOD / (2 * ROWS);
  localparam int SELF_STEP = (STEP_RAW > 0) ? STEP_RAW : 1;
  localparam int STEP_W    = $clog2(SELF_STEP + 1);
  localparam int SC_W      = $clog2(SELF_CYC + 1);
  localparam int AGE_W     = $clog2(REF_PERIOD + 1);
  localparam logic [AGE_W-1:0]  AGE_MAX  = AGE_W'(REF_PERIOD);
  localparam logic [STEP_W-1:0] STEP_END = STEP_W'(SELF_STEP - 1);
  localparam logic [SC_W-1:0]   SC_END   = SC_W'(SELF_CYC - 1);

  logic [ROW_W-1:0]  ptr_q;
  logic [STEP_W-1:0] step_q;
  logic [SC_W-1:0]   sc_q;
  logic              step_tick, ptr_adv;

  assign step_tick = self_act_i && (step_q == STEP_END);
  assign ptr_adv   = cbr_en_i || step_tick;
  assign self_go_o = cbr_hold_i && (sc_q == SC_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      step_q <= '0;
      sc_q   <= '0;
    end else begin
      if (ptr_adv) ptr_q <= ptr_q + 1'b1;
      if (!self_act_i || step_tick) step_q <= '0;
      else                          step_q <= step_q + 1'b1;
      if (!cbr_hold_i)       sc_q <= '0;
      else if (sc_q != SC_END) sc_q <= sc_q + 1'b1;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [AGE_W-1:0] age_q;
    logic             hit;

    assign hit = (ext_en_i && ext_row_i == ROW_W'(r)) ||
                 (ptr_adv && ptr_q == ROW_W'(r));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              age_q <= '0;
      else if (hit)             age_q <= '0;
      else if (age_q != AGE_MAX) age_q <= age_q + 1'b1;
    end

    assign stale_map_o[r] = (age_q == AGE_MAX);
  end
endmodule

// File: rtl/pgdram_model.sv
module pgdram_model
  import pgdram_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int ROW_W      = 3,
  parameter int COL_W      = 2,
  parameter int DW         = 4,
  parameter int REF_PERIOD = 2000,
  parameter int SELF_CYC   = 400
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ras_ni,
  input  logic                  cas_ni,
  input  logic                  we_ni,
  input  logic                  oe_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DW-1:0]         dq_i,
  output logic [DW-1:0]         dq_o,
  output logic                  dq_oe_o,
  output logic [3:0]            cyc_type_o,
  output logic                  self_ref_o,
  output logic [(1<<ROW_W)-1:0] stale_map_o,
  output logic                  stale_err_o
);
  localparam int AW = ROW_W + COL_W;

  logic [2:0] fall, rise;
  logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall;

  st_e              state_q, state_n;
  cyc_e             cyc_q, cyc_n;
  logic [ROW_W-1:0] row_q, row_n;
  logic [COL_W-1:0] col_q, col_n, col_sel;
  logic [DW-1:0]    rd_data_q, rd_data_n, mem_rdata;
  logic             rd_hold_q, rd_hold_n;
  logic             drove_q, drove_n;
  logic             any_cas_q, any_cas_n;
  logic             self_q, self_n;
  logic             mem_we, ext_en, cbr_en, self_go;
  logic [ADDR_W-1:0] unused_addr;

  assign unused_addr = addr_i;

  pgdram_edge #(.N(3)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({ras_ni, cas_ni, we_ni}),
    .fall_o (fall),
    .rise_o (rise)
  );

  assign ras_fall = fall[2];
  assign ras_rise = rise[2];
  assign cas_fall = fall[1];
  assign cas_rise = rise[1];
  assign we_fall  = fall[0];

  assign col_sel = cas_fall ? addr_i[COL_W-1:0] : col_q;

  pgdram_array #(.AW(AW), .DW(DW)) u_array (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .addr_i  ({row_q, col_sel}),
    .wdata_i (dq_i),
    .rdata_o (mem_rdata)
  );

  pgdram_refresh #(
    .ROW_W      (ROW_W),
    .REF_PERIOD (REF_PERIOD),
    .SELF_CYC   (SELF_CYC)
  ) u_refresh (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ext_en_i    (ext_en),
    .ext_row_i   (addr_i[ROW_W-1:0]),
    .cbr_en_i    (cbr_en),
    .cbr_hold_i  (state_q == ST_CBR),
    .self_act_i  (state_q == ST_SELF),
    .self_go_o   (self_go),
    .stale_map_o (stale_map_o)
  );

  always_comb begin
    state_n   = state_q;
    cyc_n     = cyc_q;
    row_n     = row_q;
    col_n     = col_q;
    rd_data_n = rd_data_q;
    rd_hold_n = rd_hold_q;
    drove_n   = drove_q;
    any_cas_n = any_cas_q;
    self_n    = self_q;
    mem_we    = 1'b0;
    ext_en    = 1'b0;
    cbr_en    = 1'b0;

    if (cas_rise) rd_hold_n = 1'b0;
    if (rd_hold_q && !oe_ni && !cas_ni) drove_n = 1'b1;

    unique case (state_q)
      ST_IDLE: begin
        if (ras_fall) begin
          if (!cas_ni) begin
            // column strobe already low: counter refresh, hidden if still driving
            state_n = ST_CBR;
            cbr_en  = 1'b1;
            cyc_n   = rd_hold_q ? CYC_HIDDEN : CYC_CBR;
          end else begin
            state_n   = ST_OPEN;
            row_n     = addr_i[ROW_W-1:0];
            ext_en    = 1'b1;
            any_cas_n = 1'b0;
          end
        end
      end
      ST_OPEN: begin
        if (ras_rise) begin
          state_n = ST_IDLE;
          if (!any_cas_q) cyc_n = CYC_RAS_ONLY;
        end else if (cas_fall) begin
          any_cas_n = 1'b1;
          col_n     = addr_i[COL_W-1:0];
          drove_n   = 1'b0;
          if (!we_ni) begin
            mem_we    = 1'b1;
            rd_hold_n = 1'b0;
            cyc_n     = CYC_EARLY_WR;
          end else begin
            rd_hold_n = 1'b1;
            rd_data_n = mem_rdata;
            cyc_n     = CYC_READ;
          end
        end else if (we_fall && !cas_ni && rd_hold_q && oe_ni) begin
          // late write; with output enable low the write is dropped
          mem_we    = 1'b1;
          rd_hold_n = 1'b0;
          cyc_n     = drove_q ? CYC_RMW : CYC_LATE_WR;
        end
      end
      ST_CBR: begin
        if (ras_rise) begin
          state_n = ST_IDLE;
        end else if (self_go) begin
          state_n = ST_SELF;
          self_n  = 1'b1;
          cyc_n   = CYC_SELF;
        end
      end
      ST_SELF: begin
        if (ras_rise) begin
          state_n = ST_IDLE;
          self_n  = 1'b0;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cyc_q     <= CYC_NONE;
      row_q     <= '0;
      col_q     <= '0;
      rd_data_q <= '0;
      rd_hold_q <= 1'b0;
      drove_q   <= 1'b0;
      any_cas_q <= 1'b0;
      self_q    <= 1'b0;
    end else begin
      state_q   <= state_n;
      cyc_q     <= cyc_n;
      row_q     <= row_n;
      col_q     <= col_n;
      rd_data_q <= rd_data_n;
      rd_hold_q <= rd_hold_n;
      drove_q   <= drove_n;
      any_cas_q <= any_cas_n;
      self_q    <= self_n;
    end
  end

  assign dq_o        = rd_data_q;
  assign dq_oe_o     = rd_hold_q && !oe_ni && !cas_ni;
  assign cyc_type_o  = cyc_q;
  assign self_ref_o  = self_q;
  assign stale_err_o = |stale_map_o;
endmodule

// File: rtl/pgdram_chk.sv
module pgdram_chk
  import pgdram_pkg::*;
#(
  parameter int DW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ras_ni,
  input logic          cas_ni,
  input logic          we_ni,
  input logic          oe_ni,
  input logic [DW-1:0] dq_o,
  input logic          dq_oe_o,
  input logic [3:0]    cyc_type_o,
  input logic          self_ref_o
);
  always_comb begin
    if (!rst_ni) a_r1_reset_quiet: assert (!dq_oe_o && !self_ref_o);
  end

  a_r2_early_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_type_o == CYC_EARLY_WR && !cas_ni) |-> !dq_oe_o);

  a_r6_blocked_keeps_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(we_ni) && !cas_ni && !oe_ni && dq_oe_o) |=>
      (cas_ni || oe_ni || (dq_oe_o && $stable(dq_o))));

  a_r9_hidden_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_ni) && !cas_ni && dq_oe_o) |=> (cyc_type_o == CYC_HIDDEN));

  a_r10_self_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_ni) |=> !self_ref_o);

  a_r10_self_entry_ras_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(self_ref_o) |-> !ras_ni);
endmodule

bind pgdram_model pgdram_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ras_ni     (ras_ni),
  .cas_ni     (cas_ni),
  .we_ni      (we_ni),
  .oe_ni      (oe_ni),
  .dq_o       (dq_o),
  .dq_oe_o    (dq_oe_o),
  .cyc_type_o (cyc_type_o),
  .self_ref_o (self_ref_o)
);

// File: tb/sim_pgdram_model.sv
`timescale 1ns/1ps
module sim_pgdram_model;
  localparam int ADDR_W = 4;
  localparam int ROW_W  = 3;
  localparam int COL_W  = 2;
  localparam int DW     = 4;
  localparam int REFP   = 2000;
  localparam int SELFC  = 400;
  localparam int ROWS   = 1 << ROW_W;

  // entry: {op(1=early write,0=read), row pins, col pins, data}
  localparam int NVEC = 10;
  localparam logic [15:0] VEC [NVEC] = '{
    16'h1_2_1_A, 16'h1_2_2_5, 16'h1_7_3_C, 16'h1_0_0_3,
    16'h0_2_1_A, 16'h0_7_3_C, 16'h1_A_5_9, 16'h0_2_1_9,
    16'h0_2_2_5, 16'h0_0_0_3
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe, self_ref, stale_err;
  logic [3:0] cyc;
  logic [ROWS-1:0] stale_map;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pgdram_model #(
    .ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W), .DW(DW),
    .REF_PERIOD(REFP), .SELF_CYC(SELFC)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .oe_ni(oe_n), .addr_i(addr), .dq_i(dq_in),
    .dq_o(dq_out), .dq_oe_o(dq_oe), .cyc_type_o(cyc),
    .self_ref_o(self_ref), .stale_map_o(stale_map), .stale_err_o(stale_err)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic early_wr(input logic [3:0] row, input logic [3:0] col, input logic [3:0] d);
    oe_n = 1'b0;
    ras_n = 1'b0; addr = row; step(2);
    addr = col; we_n = 1'b0; dq_in = d; step(2);
    cas_n = 1'b0; step(2);
    check("R2 early kind", cyc, 2);
    check("R2 early no drive", dq_oe, 0);
    cas_n = 1'b1; we_n = 1'b1; ras_n = 1'b1; step(2);
  endtask

  task automatic rd(input logic [3:0] row, input logic [3:0] col, input logic [3:0] exp);
    oe_n = 1'b0;
    ras_n = 1'b0; addr = row; step(2);
    addr = col; cas_n = 1'b0; step(2);
    check("R3 read kind", cyc, 1);
    check("R3 read drive", dq_oe, 1);
    check("R3 read data", dq_out, exp);
    cas_n = 1'b1; step(1);
    check("R3 hiz cas high", dq_oe, 0);
    ras_n = 1'b1; step(2);
  endtask

  task automatic cbr();
    cas_n = 1'b0; step(2);
    ras_n = 1'b0; addr = 4'h5; step(2);
    check("R8 cbr kind", cyc, 6);
    ras_n = 1'b1; step(1);
    cas_n = 1'b1; step(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    // R1 reset state
    check("R1 oe in reset", dq_oe, 0);
    check("R1 self in reset", self_ref, 0);
    rst_n = 1'b1; step(2);
    check("R1 kind", cyc, 0);
    check("R1 stale err", stale_err, 0);

    // R11: nothing refreshed for a full period
    step(REFP + 5);
    check("R11 all stale", stale_map, 8'hFF);
    check("R11 err", stale_err, 1);

    // R8: pointer starts at 0, pins ignored
    cbr();
    check("R8 row0 refreshed", stale_map, 8'hFE);
    cbr();
    check("R8 row1 refreshed", stale_map, 8'hFC);

    // R7 + R12: row-only cycle with high pin set -> row 3
    ras_n = 1'b0; addr = 4'hB; step(2);
    ras_n = 1'b1; step(2);
    check("R7 ras-only kind", cyc, 5);
    check("R7 no drive", dq_oe, 0);
    check("R12 row 3 refreshed", stale_map, 8'hF4);

    // table walk: R2, R3, R12
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][12]) early_wr(VEC[i][11:8], VEC[i][7:4], VEC[i][3:0]);
      else            rd(VEC[i][11:8], VEC[i][7:4], VEC[i][3:0]);
    end

    // R7: row-only cycle left data intact
    ras_n = 1'b0; addr = 4'h2; step(2); ras_n = 1'b1; step(2);
    rd(4'h2, 4'h2, 4'h5);

    // R4 late write
    early_wr(4'h5, 4'h2, 4'h1);
    oe_n = 1'b1;
    ras_n = 1'b0; addr = 4'h5; step(2);
    addr = 4'h2; cas_n = 1'b0; step(2);
    check("R3 oe high no drive", dq_oe, 0);
    we_n = 1'b0; dq_in = 4'h6; step(2);
    check("R4 late kind", cyc, 3);
    cas_n = 1'b1; we_n = 1'b1; ras_n = 1'b1; step(2);
    rd(4'h5, 4'h2, 4'h6);

    // R5 read-modify-write
    ras_n = 1'b0; addr = 4'h5; step(2);
    addr = 4'h2; cas_n = 1'b0; step(2);
    check("R5 old data out", dq_out, 6);
    oe_n = 1'b1; step(1);
    we_n = 1'b0; dq_in = 4'h7; step(2);
    check("R5 rmw kind", cyc, 4);
    cas_n = 1'b1; we_n = 1'b1; ras_n = 1'b1; oe_n = 1'b0; step(2);
    rd(4'h5, 4'h2, 4'h7);

    // R6 late write blocked by output enable low
    ras_n = 1'b0; addr = 4'h5; step(2);
    addr = 4'h2; cas_n = 1'b0; step(2);
    we_n = 1'b0; dq_in = 4'h2; step(2);
    check("R6 kind stays read", cyc, 1);
    check("R6 still drives", dq_oe, 1);
    check("R6 old data", dq_out, 7);
    cas_n = 1'b1; we_n = 1'b1; ras_n = 1'b1; step(2);
    rd(4'h5, 4'h2, 4'h7);

    // R9 hidden refresh
    ras_n = 1'b0; addr = 4'h2; step(2);
    addr = 4'h2; cas_n = 1'b0; step(2);
    ras_n = 1'b1; step(2);
    check("R9 drive across ras high", dq_oe, 1);
    ras_n = 1'b0; step(2);
    check("R9 hidden kind", cyc, 7);
    check("R9 data kept", dq_out, 5);
    check("R9 drive kept", dq_oe, 1);
    ras_n = 1'b1; step(1);
    cas_n = 1'b1; step(2);
    check("R3 hiz after hidden", dq_oe, 0);

    // R10 self refresh
    cas_n = 1'b0; step(2);
    ras_n = 1'b0; step(SELFC - 10);
    check("R10 not yet self", self_ref, 0);
    step(15);
    check("R10 self entered", self_ref, 1);
    check("R10 self kind", cyc, 8);
    step(1100);
    ras_n = 1'b1; step(2);
    check("R10 self exit", self_ref, 0);
    check("R10 all rows refreshed", stale_map, 0);
    cas_n = 1'b1; step(2);

    // R11 lapse after period
    step(REFP + 10);
    check("R11 stale after lapse", stale_err, 1);
    check("R11 map full", stale_map, 8'hFF);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule